// File: doc/BRIEF.md
# Grouped GPIO Controller with Pin Interrupts

A memory-mapped controller for a parameterised number of general-purpose pins. Software sees every pin through its own small window of word registers. Through that window it drives the pin's output value and output enable, reads back the synchronised pad level, and selects the event that raises the pin's pending flag. The event is a rising, falling or either edge, or a high or low level. Two independent mask bits decide whether a pending pin is reported upward.

Pins are gathered into groups of sixteen. Each group has a read-only summary word that shows the reported pins of that group, and one interrupt output. An interrupt handler reads the summary word of the group that fired, services the pins it lists, and clears each pin's pending flag by writing zero to it. Pad inputs are resynchronised inside the block. Input debouncing, clocks and resets come from elsewhere.

Top module: `gpio_grp_ctrl`

## Requirements
- R1: While rst_ni is low, every pad_oe_o bit is 0, every irq_o bit is 0, each pin's pending flag and trigger field read 0, and both of its mask bits read 1.
- R2: Pin p owns the byte addresses 0x40*p to 0x40*p+0x3F. The fields sit in bit 0 of the word at these offsets: input 0x00, output 0x04, direction 0x08, pin mask 0x0C, group mask 0x10, pending 0x14. The trigger field is in bits 2:0 at offset 0x18. The writable fields read back the last value written.
- R3: A direction bit of 1 makes the pin an input with pad_oe_o low. A direction bit of 0 sets pad_oe_o high, with pad_o equal to the output bit. Both take effect at the clock edge of the write.
- R4: The input field shows the pad through a two-flop synchroniser. A pad change sampled at clock edge k is readable after edge k+1 and not before.
- R5: Trigger value 4 flags a rising edge, 2 a falling edge and 6 either edge. A pad transition sampled at edge k sets the pending flag at edge k+2.
- R6: Trigger value 1 flags a high level and 0 a low level. While the level holds, the flag is set again on every cycle, so a clear has no lasting effect.
- R7: Writing 0 to the pending field clears the flag. Writing 1 leaves it unchanged. A trigger event in the same cycle as a clear wins.
- R8: A pending pin is reported to its group only while both of its mask bits are 0. Masking does not alter the pending flag itself.
- R9: The summary word of group g is at 0x4000+4*g, and its bit n is the reported state of pin 16*g+n. irq_o[g] is high exactly while that word is nonzero.
- R10: Reads of unmapped offsets, of addresses outside all windows, and of summary words for groups that do not exist return 0. Writes to the summary words change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_en_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, valid during a read strobe |
| pad_i | input | N_PINS | Pad input levels |
| pad_o | output | N_PINS | Pad output values |
| pad_oe_o | output | N_PINS | Pad output enables, 1 drives |
| irq_o | output | N_GROUPS | One interrupt per group of sixteen pins |

## Verification
Register writes land at the clock edge that takes the strobe, so pad_o, pad_oe_o and the readback are checked at the next falling edge. A pad change has a fixed latency. The input field changes one edge after the first sampling edge, and pending and irq_o change two edges after it. The bench samples irq_o at each falling edge across that window to confirm it stays low before the due cycle and is high in it. Randomised edge cases wait four cycles before reading pending, well past the latency, and level cases wait long enough for the synchroniser to settle before a clear is attempted.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;
  localparam int unsigned GROUP_SIZE = 16;
  localparam int unsigned PIN_SPAN_B = 64;
  localparam int unsigned SUM_BASE   = 'h4000;

  localparam logic [5:0] OFF_IN    = 6'h00;
  localparam logic [5:0] OFF_OUT   = 6'h04;
  localparam logic [5:0] OFF_DIR   = 6'h08;
  localparam logic [5:0] OFF_PMASK = 6'h0C;
  localparam logic [5:0] OFF_GMASK = 6'h10;
  localparam logic [5:0] OFF_PEND  = 6'h14;
  localparam logic [5:0] OFF_TRIG  = 6'h18;

  typedef enum logic [2:0] {
    TRIG_LVL_LO = 3'd0,
    TRIG_LVL_HI = 3'd1,
    TRIG_FALL   = 3'd2,
    TRIG_RISE   = 3'd4,
    TRIG_BOTH   = 3'd6
  } trig_e;

  typedef struct packed {
    logic out;
    logic dir;
    logic pmask;
    logic gmask;
    logic pend;
    logic trig;
  } pin_wr_t;
endpackage

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
  import gpio_grp_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pad_i,
  input  pin_wr_t       wr_i,
  input  logic [2:0]    wdata_i,
  output logic          in_o,
  output logic          out_o,
  output logic          dir_o,
  output logic          pmask_o,
  output logic          gmask_o,
  output logic          pend_o,
  output logic [2:0]    trig_o,
  output logic          report_o
);
  logic s1_q, s2_q, prev_q;
  logic out_q, dir_q, pmask_q, gmask_q, pend_q;
  logic [2:0] trig_q;
  logic edge_mode, evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pad_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  // bit 0 is polarity in level mode, ignored once any edge bit is set
  always_comb begin
    edge_mode = |trig_q[2:1];
    if (edge_mode) evt = (trig_q[2] & s2_q & ~prev_q) | (trig_q[1] & ~s2_q & prev_q);
    else           evt = trig_q[0] ? s2_q : ~s2_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= 1'b0;
      dir_q   <= 1'b1;
      pmask_q <= 1'b1;
      gmask_q <= 1'b1;
      pend_q  <= 1'b0;
      trig_q  <= 3'd0;
    end else begin
      if (wr_i.out)   out_q   <= wdata_i[0];
      if (wr_i.dir)   dir_q   <= wdata_i[0];
      if (wr_i.pmask) pmask_q <= wdata_i[0];
      if (wr_i.gmask) gmask_q <= wdata_i[0];
      if (wr_i.trig)  trig_q  <= wdata_i;
      if (evt)                            pend_q <= 1'b1;
      else if (wr_i.pend && !wdata_i[0])  pend_q <= 1'b0;
    end
  end

  assign in_o     = s2_q;
  assign out_o    = out_q;
  assign dir_o    = dir_q;
  assign pmask_o  = pmask_q;
  assign gmask_o  = gmask_q;
  assign pend_o   = pend_q;
  assign trig_o   = trig_q;
  assign report_o = pend_q & ~pmask_q & ~gmask_q;

  // R5
  rise_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(trig_q[2] && s2_q && !prev_q) |-> pend_q);
  // R5
  fall_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(trig_q[1] && !s2_q && prev_q) |-> pend_q);
  // R6
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(trig_q == 3'd1 && s2_q) |-> pend_q);
  // R7
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i.pend && !wdata_i[0] && !evt) |-> !pend_q);
  // R7
  pend_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!evt && !wr_i.pend) |-> (pend_q == $past(pend_q)));
  // R3
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i.dir) |-> (dir_q == $past(wdata_i[0])));
endmodule

// File: rtl/gpio_group_irq.sv
module gpio_group_irq
  import gpio_grp_pkg::*;
(
  input  logic [GROUP_SIZE-1:0] report_i,
  output logic [31:0]           summary_o,
  output logic                  irq_o
);
  assign summary_o = 32'(report_i);
  assign irq_o     = |report_i;
endmodule

// File: rtl/gpio_grp_ctrl.sv
module gpio_grp_ctrl
  import gpio_grp_pkg::*;
#(
  parameter int unsigned N_PINS   = 32,
  parameter int unsigned ADDR_W   = 15,
  parameter int unsigned N_GROUPS = (N_PINS + GROUP_SIZE - 1) / GROUP_SIZE
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_en_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [N_PINS-1:0]   pad_i,
  output logic [N_PINS-1:0]   pad_o,
  output logic [N_PINS-1:0]   pad_oe_o,
  output logic [N_GROUPS-1:0] irq_o
);
  localparam int unsigned PIN_IDX_W = (N_PINS > 1) ? $clog2(N_PINS) : 1;
  localparam int unsigned GRP_IDX_W = (N_GROUPS > 1) ? $clog2(N_GROUPS) : 1;
  localparam int unsigned PIN_END   = N_PINS * PIN_SPAN_B;
  localparam int unsigned SUM_END   = SUM_BASE + 4 * N_GROUPS;
  localparam int unsigned PAD_PINS  = N_GROUPS * GROUP_SIZE;

  logic [31:0]          a32;
  logic                 in_pin_win, in_sum_win, wr_en, rd_en;
  logic [PIN_IDX_W-1:0] pin_sel;
  logic [GRP_IDX_W-1:0] grp_sel;
  logic [5:0]           off;

  assign a32        = 32'(bus_addr_i);
  assign in_pin_win = a32 < PIN_END;
  assign in_sum_win = (a32 >= SUM_BASE) && (a32 < SUM_END);
  assign pin_sel    = PIN_IDX_W'(a32 >> 6);
  assign grp_sel    = GRP_IDX_W'((a32 - SUM_BASE) >> 2);
  assign off        = {a32[5:2], 2'b00};
  assign wr_en      = bus_en_i & bus_we_i & in_pin_win;
  assign rd_en      = bus_en_i & ~bus_we_i;

  logic [N_PINS-1:0] in_v, out_v, dir_v, pm_v, gm_v, pd_v, rep_v;
  logic [2:0]        trig_v [N_PINS];

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    pin_wr_t wr;
    logic    hit;
    assign hit      = wr_en && (pin_sel == PIN_IDX_W'(i));
    assign wr.out   = hit && (off == OFF_OUT);
    assign wr.dir   = hit && (off == OFF_DIR);
    assign wr.pmask = hit && (off == OFF_PMASK);
    assign wr.gmask = hit && (off == OFF_GMASK);
    assign wr.pend  = hit && (off == OFF_PEND);
    assign wr.trig  = hit && (off == OFF_TRIG);

    gpio_pin_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pad_i    (pad_i[i]),
      .wr_i     (wr),
      .wdata_i  (bus_wdata_i[2:0]),
      .in_o     (in_v[i]),
      .out_o    (out_v[i]),
      .dir_o    (dir_v[i]),
      .pmask_o  (pm_v[i]),
      .gmask_o  (gm_v[i]),
      .pend_o   (pd_v[i]),
      .trig_o   (trig_v[i]),
      .report_o (rep_v[i])
    );
  end

  assign pad_o    = out_v;
  assign pad_oe_o = ~dir_v;

  logic [PAD_PINS-1:0] rep_pad;
  logic [31:0]         sum_v [N_GROUPS];
  assign rep_pad = PAD_PINS'(rep_v);

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    gpio_group_irq u_grp (
      .report_i  (rep_pad[g*GROUP_SIZE +: GROUP_SIZE]),
      .summary_o (sum_v[g]),
      .irq_o     (irq_o[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en && in_pin_win) begin
      unique case (off)
        OFF_IN:    bus_rdata_o = 32'(in_v[pin_sel]);
        OFF_OUT:   bus_rdata_o = 32'(out_v[pin_sel]);
        OFF_DIR:   bus_rdata_o = 32'(dir_v[pin_sel]);
        OFF_PMASK: bus_rdata_o = 32'(pm_v[pin_sel]);
        OFF_GMASK: bus_rdata_o = 32'(gm_v[pin_sel]);
        OFF_PEND:  bus_rdata_o = 32'(pd_v[pin_sel]);
        OFF_TRIG:  bus_rdata_o = 32'(trig_v[pin_sel]);
        default:   bus_rdata_o = '0;
      endcase
    end else if (rd_en && in_sum_win) begin
      bus_rdata_o = sum_v[grp_sel];
    end
  end

  // R9
  sum_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && in_sum_win) |-> ((bus_rdata_o != 32'd0) == irq_o[grp_sel]));
  // R1
  rst_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pad_oe_o == '0));
endmodule

// File: tb/tb_gpio_grp_ctrl.sv
module tb_gpio_grp_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N_PINS     = 32;
  localparam int N_GROUPS   = 2;
  localparam int ADDR_W     = 15;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                bus_en = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0]   bus_addr = '0;
  logic [31:0]         bus_wdata = '0;
  logic [31:0]         bus_rdata;
  logic [N_PINS-1:0]   pads = '0;
  logic [N_PINS-1:0]   pad_o, pad_oe;
  logic [N_GROUPS-1:0] irq;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_grp_ctrl #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(bus_en), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .pad_i(pads), .pad_o(pad_o), .pad_oe_o(pad_oe), .irq_o(irq)
  );

  localparam int A_IN = 'h00, A_OUT = 'h04, A_DIR = 'h08, A_PM = 'h0C,
                 A_GM = 'h10, A_PD = 'h14, A_TR = 'h18;

  function automatic int pa(int p, int o);
    return p * 64 + o;
  endfunction

  function automatic bit exp_evt(int t, bit o, bit n);
    if (t[2:1] != 0) return (t[2] && !o && n) || (t[1] && o && !n);
    return t[0] ? n : !n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
    #1 d = int'(bus_rdata);
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic arm(int p, int t);
    wr(pa(p, A_TR), t); wr(pa(p, A_PD), 0); wr(pa(p, A_PM), 0); wr(pa(p, A_GM), 0);
  endtask

  task automatic disarm(int p);
    wr(pa(p, A_PM), 1); wr(pa(p, A_GM), 1); wr(pa(p, A_TR), 2); wr(pa(p, A_PD), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d, p, t, e, o;
    bit ov, nv;
    void'($urandom(32'd7311));
    tick(2);
    // R1 during reset
    chk(pad_oe == '0, "R1 oe", int'(pad_oe), 0);
    chk(irq == '0, "R1 irq", int'(irq), 0);
    rd(pa(5, A_TR), d); chk(d == 0, "R1 trig", d, 0);
    rd(pa(5, A_PM), d); chk(d == 1, "R1 pmask", d, 1);
    rd(pa(5, A_GM), d); chk(d == 1, "R1 gmask", d, 1);
    rd(pa(5, A_PD), d); chk(d == 0, "R1 pend", d, 0);
    rst_n = 1'b1;
    tick(2);
    for (int i = 0; i < N_PINS; i++) begin wr(pa(i, A_TR), 2); wr(pa(i, A_PD), 0); end

    // R2 R3 random output and direction
    for (int k = 0; k < 40; k++) begin
      p = $urandom % N_PINS; o = $urandom % 2; e = $urandom % 2;
      wr(pa(p, A_OUT), o); wr(pa(p, A_DIR), e);
      chk(pad_o[p] == o[0], "R3 pad_o", pad_o[p], o);
      chk(pad_oe[p] == !e[0], "R3 pad_oe", pad_oe[p], !e[0]);
      rd(pa(p, A_OUT), d); chk(d == o, "R2 out readback", d, o);
      rd(pa(p, A_DIR), d); chk(d == e, "R2 dir readback", d, e);
    end

    // R4 input value after sync
    pads = N_PINS'($urandom);
    tick(3);
    for (int k = 0; k < 6; k++) begin
      p = $urandom % N_PINS;
      rd(pa(p, A_IN), d); chk(d == int'(pads[p]), "R4 input", d, pads[p]);
    end
    pads = '0; tick(4);
    p = 11;
    pads[p] = 1'b1; tick(1);
    rd(pa(p, A_IN), d); chk(d == 0, "R4 not yet", d, 0);
    rd(pa(p, A_IN), d); chk(d == 1, "R4 due", d, 1);
    pads = '0; tick(4);
    for (int i = 0; i < N_PINS; i++) wr(pa(i, A_PD), 0);

    // R5 randomised edge triggers
    for (int k = 0; k < 30; k++) begin
      p = $urandom % N_PINS;
      case ($urandom % 3) 0: t = 2; 1: t = 4; default: t = 6; endcase
      ov = 1'($urandom); nv = 1'($urandom);
      pads[p] = ov; tick(4);
      arm(p, t);
      rd(pa(p, A_TR), d); chk(d == t, "R2 trig readback", d, t);
      rd(pa(p, A_PD), d); chk(d == 0, "R7 clear", d, 0);
      pads[p] = nv; tick(4);
      rd(pa(p, A_PD), d); chk(d == int'(exp_evt(t, ov, nv)), "R5 edge pend", d, exp_evt(t, ov, nv));
      chk(irq[p/16] == exp_evt(t, ov, nv), "R9 irq", irq[p/16], exp_evt(t, ov, nv));
      wr(pa(p, A_PD), 0);
      rd(pa(p, A_PD), d); chk(d == 0, "R7 clear after", d, 0);
      disarm(p);
    end
    pads = '0; tick(4);
    for (int i = 0; i < N_PINS; i++) wr(pa(i, A_PD), 0);

    // R5 latency
    p = 3; arm(p, 4); tick(2);
    pads[p] = 1'b1;
    tick(1); chk(irq[0] == 0, "R5 k", irq[0], 0);
    tick(1); chk(irq[0] == 0, "R5 k+1", irq[0], 0);
    tick(1); chk(irq[0] == 1, "R5 k+2", irq[0], 1);
    disarm(p); pads[p] = 1'b0; tick(4); wr(pa(p, A_PD), 0);

    // R6 level high and low
    p = 20; pads[p] = 1'b1; tick(3);
    arm(p, 1); tick(2);
    rd(pa(p, A_PD), d); chk(d == 1, "R6 high set", d, 1);
    wr(pa(p, A_PD), 0);
    rd(pa(p, A_PD), d); chk(d == 1, "R6 clear not sticky", d, 1);
    pads[p] = 1'b0; tick(3); wr(pa(p, A_PD), 0);
    rd(pa(p, A_PD), d); chk(d == 0, "R6 clear after drop", d, 0);
    wr(pa(p, A_TR), 0); tick(2);
    rd(pa(p, A_PD), d); chk(d == 1, "R6 low set", d, 1);
    pads[p] = 1'b1; tick(3); wr(pa(p, A_PD), 0);
    rd(pa(p, A_PD), d); chk(d == 0, "R6 low cleared", d, 0);
    disarm(p); pads[p] = 1'b0; tick(4); wr(pa(p, A_PD), 0);

    // R7 writing 1 has no effect
    p = 7; arm(p, 4); wr(pa(p, A_PD), 1);
    rd(pa(p, A_PD), d); chk(d == 0, "R7 write one", d, 0);
    disarm(p);

    // R8 masks
    p = 9; arm(p, 4); pads[p] = 1'b1; tick(4);
    chk(irq[0] == 1, "R8 unmasked irq", irq[0], 1);
    wr(pa(p, A_PM), 1);
    chk(irq[0] == 0, "R8 pmask irq", irq[0], 0);
    rd(pa(p, A_PD), d); chk(d == 1, "R8 pend kept", d, 1);
    rd('h4000, d); chk(d == 0, "R8 summary masked", d, 0);
    wr(pa(p, A_PM), 0); wr(pa(p, A_GM), 1);
    chk(irq[0] == 0, "R8 gmask irq", irq[0], 0);
    wr(pa(p, A_GM), 0);
    rd('h4000, d); chk(d == (1 << 9), "R8 summary", d, 1 << 9);
    disarm(p); pads[p] = 1'b0; tick(4); wr(pa(p, A_PD), 0);

    // R9 group summary
    arm(17, 4); arm(30, 4);
    pads[17] = 1'b1; pads[30] = 1'b1; tick(4);
    rd('h4004, d); chk(d == 32'h4002, "R9 summary g1", d, 32'h4002);
    rd('h4000, d); chk(d == 0, "R9 summary g0", d, 0);
    chk(irq == 2'b10, "R9 irq vector", int'(irq), 2);
    // R10 summary write ignored
    wr('h4004, 0);
    rd('h4004, d); chk(d == 32'h4002, "R10 summary ro", d, 32'h4002);
    disarm(17); disarm(30);

    // R10 unmapped reads
    rd(pa(0, 'h1C), d); chk(d == 0, "R10 off 1C", d, 0);
    rd(pa(0, 'h20), d); chk(d == 0, "R10 off 20", d, 0);
    rd('h3FFC, d); chk(d == 0, "R10 gap", d, 0);
    rd('h4008, d); chk(d == 0, "R10 no group", d, 0);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule